// File: doc/BRIEF.md
# Stack-Machine Syllable Execution Unit

This unit runs the 6-bit syllables of a zero-operand stack processor. Operands live in an on-chip register-file stack indexed by a depth counter. Every operation takes its inputs from the top entries, removes what it consumes and leaves any result on top. A sequencer offers one item at a time over a valid/ready handshake. An item is either a 6-bit syllable or a full 32-bit literal word to push. The unit answers with a one-cycle redirect request when control flow changes, and with read and write strobes on a single-word data-memory port.

Most syllables finish in the cycle they are accepted. A load holds the handshake for one extra cycle while the memory returns its word. Stack misuse stops the unit and raises a sticky fault. This covers reading below the bottom entry and pushing onto a full stack. Two opcodes that are decoded but not built also stop the unit, with their own sticky flag. Reset is the only way out of the stopped state.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset, depth is 0, the status word is 0, in_ready is 1, and halted, fault_stack and fault_unimpl are all 0.
- R2: A syllable with bit 5 set pushes its low 5 bits zero-extended to 32 bits. An accepted item with in_lit=1 pushes in_word unchanged.
- R3: If an accepted syllable needs more entries than the stack holds, or would push onto a stack of DEPTH entries, it sets fault_stack and halts, and the stack keeps its contents and depth.
- R4: Syllable 011xxx pushes a copy of the entry x places below the top, with x=0 naming the top itself. It needs more than x entries.
- R5: Syllable 010xxx removes the top and writes it into the entry x places below the new top. It needs at least x+2 entries.
- R6: 001000 AND, 001001 OR and 001011 XOR each consume the top and next entries and push the result, so depth drops by one. 001010 NOT replaces the top with its complement.
- R7: 001100 consumes top and next and pushes their 32-bit wrapping sum. 001101 exchanges top and next.
- R8: 000100 consumes a signed amount (top) and a value (next) and pushes the shifted value. A positive amount shifts left, a negative amount shifts right logically, and a magnitude of 32 or more gives 0.
- R9: 000110 consumes the top and sets status bit 1 to its bit 31 and status bit 0 to whether it equals zero. Status bits 31..2 always read 0, and no other syllable changes the status word.
- R10: 001110 consumes the top and asserts redir_valid with redir_pc equal to it in the accepting cycle. 000111 consumes top and next and redirects to the top value only when next is zero.
- R11: 000010 asserts mem_rd with the top as address in the accepting cycle. It drops in_ready for the following cycle, and the word on mem_rdata in that cycle replaces the address on top. 000011 asserts mem_wr with address from the top and data from next, then consumes both.
- R12: 000000 halts the unit: in_ready stays 0 and no later item changes the stack until reset. 000001 changes nothing.
- R13: 000101 and 001111 set fault_unimpl and halt without touching the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sequencer offers an item |
| in_ready | output | 1 | Unit can accept an item this cycle |
| in_lit | input | 1 | Item is a 32-bit literal push rather than a syllable |
| in_syl | input | 6 | Syllable code |
| in_word | input | 32 | Literal word |
| redir_valid | output | 1 | Redirect request, one cycle |
| redir_pc | output | 32 | Redirect target |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| mem_addr | output | 32 | Data-memory address |
| mem_wdata | output | 32 | Data-memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| tos | output | 32 | Current top entry, 0 when empty |
| depth | output | $clog2(DEPTH+1) | Entries on the stack |
| psw | output | 32 | Status word {30'b0, negative, zero} |
| halted | output | 1 | Unit stopped |
| fault_stack | output | 1 | Sticky stack-bounds fault |
| fault_unimpl | output | 1 | Sticky unimplemented-opcode flag |

## Verification
Some rules hold every cycle and are checked by the properties. Depth never exceeds the configured size, and the upper status bits stay clear. A stopped unit never raises in_ready and stays stopped. Either fault flag implies the stopped state, a load is always followed by a stall cycle, redirects only occur on an accepted item, and a literal push always grows the depth by one. The arithmetic and data movement can only be shown by the bench's scenarios. That covers the logic results, wrapping add, the signed shift, the stack-relative copy and overwrite offsets, branch-not-taken, and the stack surviving a faulting syllable unchanged. The scenarios also check the exact redirect and memory addresses against a queue of expected events.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [4:0] {
        OP_LIT, OP_IMM, OP_LDSP, OP_STSP,
        OP_AND, OP_OR, OP_NOT, OP_XOR, OP_ADD, OP_SWAP,
        OP_JMP, OP_CTX, OP_SHIFT, OP_CAS, OP_TEST, OP_BRZ,
        OP_LOAD, OP_STORE, OP_NOP, OP_HALT
    } op_e;

    typedef enum logic [1:0] { ST_RUN, ST_LWAIT, ST_STOP } state_e;

    // need: entries required; grow: net push of one; drop: net entries removed
    typedef struct packed {
        op_e        op;
        logic [2:0] ofs;
        logic [3:0] need;
        logic       grow;
        logic [1:0] drop;
    } dec_t;

    function automatic dec_t decode(input logic lit, input logic [5:0] s);
        dec_t d;
        d.op   = OP_NOP;
        d.ofs  = s[2:0];
        d.need = 4'd0;
        d.grow = 1'b0;
        d.drop = 2'd0;
        if (lit) begin
            d.op = OP_LIT; d.grow = 1'b1;
        end else if (s[5]) begin
            d.op = OP_IMM; d.grow = 1'b1;
        end else if (s[5:3] == 3'b011) begin
            d.op = OP_LDSP; d.grow = 1'b1; d.need = {1'b0, s[2:0]} + 4'd1;
        end else if (s[5:3] == 3'b010) begin
            d.op = OP_STSP; d.drop = 2'd1; d.need = {1'b0, s[2:0]} + 4'd2;
        end else begin
            case (s)
                6'b001000: begin d.op = OP_AND;   d.need = 4'd2; d.drop = 2'd1; end
                6'b001001: begin d.op = OP_OR;    d.need = 4'd2; d.drop = 2'd1; end
                6'b001010: begin d.op = OP_NOT;   d.need = 4'd1; end
                6'b001011: begin d.op = OP_XOR;   d.need = 4'd2; d.drop = 2'd1; end
                6'b001100: begin d.op = OP_ADD;   d.need = 4'd2; d.drop = 2'd1; end
                6'b001101: begin d.op = OP_SWAP;  d.need = 4'd2; end
                6'b001110: begin d.op = OP_JMP;   d.need = 4'd1; d.drop = 2'd1; end
                6'b001111: d.op = OP_CTX;
                6'b000100: begin d.op = OP_SHIFT; d.need = 4'd2; d.drop = 2'd1; end
                6'b000101: d.op = OP_CAS;
                6'b000110: begin d.op = OP_TEST;  d.need = 4'd1; d.drop = 2'd1; end
                6'b000111: begin d.op = OP_BRZ;   d.need = 4'd2; d.drop = 2'd2; end
                6'b000010: begin d.op = OP_LOAD;  d.need = 4'd1; end
                6'b000011: begin d.op = OP_STORE; d.need = 4'd2; d.drop = 2'd2; end
                6'b000001: d.op = OP_NOP;
                default:   d.op = OP_HALT;
            endcase
        end
        return d;
    endfunction

    // signed amount: positive shifts left, negative shifts right logically
    function automatic word_t shift_signed(input word_t v, input word_t amt);
        word_t mag;
        mag = amt[WORD_W-1] ? (~amt + word_t'(1)) : amt;
        if (mag >= word_t'(WORD_W)) return '0;
        return amt[WORD_W-1] ? (v >> mag[4:0]) : (v << mag[4:0]);
    endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
(
    input  op_e   op,
    input  word_t a_top,
    input  word_t b_nxt,
    output word_t y
);
    always_comb begin
        case (op)
            OP_AND:   y = a_top & b_nxt;
            OP_OR:    y = a_top | b_nxt;
            OP_XOR:   y = a_top ^ b_nxt;
            OP_NOT:   y = ~a_top;
            OP_ADD:   y = a_top + b_nxt;
            OP_SHIFT: y = shift_signed(b_nxt, a_top);
            default:  y = a_top;
        endcase
    end
endmodule

// File: rtl/stk_regstack.sv
module stk_regstack
    import stk_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [IW-1:0] wi_a,
    input  word_t         wd_a,
    input  logic          we_b,
    input  logic [IW-1:0] wi_b,
    input  word_t         wd_b,
    input  logic [IW-1:0] ri_top,
    input  logic [IW-1:0] ri_nxt,
    input  logic [IW-1:0] ri_ofs,
    output word_t         rd_top,
    output word_t         rd_nxt,
    output word_t         rd_ofs
);
    word_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) slots[wi_a] <= wd_a;
        if (we_b) slots[wi_b] <= wd_b;
    end

    assign rd_top = slots[ri_top];
    assign rd_nxt = slots[ri_nxt];
    assign rd_ofs = slots[ri_ofs];
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
    import stk_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_lit,
    input  logic [5:0]    in_syl,
    input  logic [31:0]   in_word,
    output logic          redir_valid,
    output logic [31:0]   redir_pc,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   tos,
    output logic [CW-1:0] depth,
    output logic [31:0]   psw,
    output logic          halted,
    output logic          fault_stack,
    output logic          fault_unimpl
);
    state_e        state;
    logic [CW-1:0] cnt;
    logic [1:0]    flags;
    dec_t          dec;
    logic          accept, unimpl, bad_depth, go;
    logic [IW-1:0] idx_top, idx_nxt, idx_new, idx_ofs, idx_stsp;
    word_t         rd_top, rd_nxt, rd_ofs, alu_y;
    logic          we_a, we_b;
    logic [IW-1:0] wi_a, wi_b;
    word_t         wd_a, wd_b;

    assign dec       = decode(in_lit, in_syl);
    assign in_ready  = (state == ST_RUN);
    assign accept    = in_valid && in_ready;
    assign unimpl    = (dec.op == OP_CTX) || (dec.op == OP_CAS);
    assign bad_depth = (int'(cnt) < int'(dec.need)) || (dec.grow && int'(cnt) == DEPTH);
    assign go        = accept && !unimpl && !bad_depth;

    assign idx_top  = IW'(cnt - CW'(1));
    assign idx_nxt  = IW'(cnt - CW'(2));
    assign idx_new  = IW'(cnt);
    assign idx_ofs  = IW'(cnt - CW'(1) - CW'(dec.ofs));
    assign idx_stsp = IW'(cnt - CW'(2) - CW'(dec.ofs));

    stk_regstack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk),
        .we_a(we_a), .wi_a(wi_a), .wd_a(wd_a),
        .we_b(we_b), .wi_b(wi_b), .wd_b(wd_b),
        .ri_top(idx_top), .ri_nxt(idx_nxt), .ri_ofs(idx_ofs),
        .rd_top(rd_top), .rd_nxt(rd_nxt), .rd_ofs(rd_ofs)
    );

    stk_alu u_alu (.op(dec.op), .a_top(rd_top), .b_nxt(rd_nxt), .y(alu_y));

    always_comb begin
        we_a = 1'b0; wi_a = idx_top; wd_a = rd_top;
        we_b = 1'b0; wi_b = idx_nxt; wd_b = rd_top;
        if (state == ST_LWAIT) begin
            we_a = 1'b1; wd_a = mem_rdata;
        end else if (go) begin
            case (dec.op)
                OP_IMM:  begin we_a = 1'b1; wi_a = idx_new; wd_a = word_t'(in_syl[4:0]); end
                OP_LIT:  begin we_a = 1'b1; wi_a = idx_new; wd_a = in_word; end
                OP_LDSP: begin we_a = 1'b1; wi_a = idx_new; wd_a = rd_ofs; end
                OP_STSP: begin we_a = 1'b1; wi_a = idx_stsp; wd_a = rd_top; end
                OP_AND, OP_OR, OP_XOR, OP_ADD, OP_SHIFT:
                         begin we_a = 1'b1; wi_a = idx_nxt; wd_a = alu_y; end
                OP_NOT:  begin we_a = 1'b1; wi_a = idx_top; wd_a = alu_y; end
                OP_SWAP: begin
                    we_a = 1'b1; wi_a = idx_top; wd_a = rd_nxt;
                    we_b = 1'b1; wi_b = idx_nxt; wd_b = rd_top;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_RUN;
            cnt          <= '0;
            flags        <= '0;
            fault_stack  <= 1'b0;
            fault_unimpl <= 1'b0;
        end else begin
            case (state)
                ST_RUN: if (accept) begin
                    if (unimpl) begin
                        fault_unimpl <= 1'b1;
                        state        <= ST_STOP;
                    end else if (bad_depth) begin
                        fault_stack <= 1'b1;
                        state       <= ST_STOP;
                    end else begin
                        cnt <= cnt + CW'(dec.grow) - CW'(dec.drop);
                        if (dec.op == OP_TEST)
                            flags <= {rd_top[WORD_W-1], rd_top == '0};
                        if (dec.op == OP_HALT)      state <= ST_STOP;
                        else if (dec.op == OP_LOAD) state <= ST_LWAIT;
                    end
                end
                ST_LWAIT: state <= ST_RUN;
                default:  state <= ST_STOP;
            endcase
        end
    end

    assign redir_valid = go && ((dec.op == OP_JMP) || (dec.op == OP_BRZ && rd_nxt == '0));
    assign redir_pc    = rd_top;
    assign mem_rd      = go && (dec.op == OP_LOAD);
    assign mem_wr      = go && (dec.op == OP_STORE);
    assign mem_addr    = rd_top;
    assign mem_wdata   = rd_nxt;
    assign tos         = (cnt == '0) ? '0 : rd_top;
    assign depth       = cnt;
    assign psw         = {30'b0, flags};
    assign halted      = (state == ST_STOP);
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_lit,
    input logic          redir_valid,
    input logic          mem_rd,
    input logic [CW-1:0] depth,
    input logic [31:0]   psw,
    input logic          halted,
    input logic          fault_stack,
    input logic          fault_unimpl
);
    p_depth_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(depth) <= DEPTH);

    p_fault_halts_r3: assert property (@(posedge clk) disable iff (rst)
        fault_stack |-> halted);

    p_unimpl_halts_r13: assert property (@(posedge clk) disable iff (rst)
        fault_unimpl |-> halted);

    p_psw_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        psw[31:2] == 30'b0);

    p_halt_blocks_r12: assert property (@(posedge clk) disable iff (rst)
        halted |-> !in_ready);

    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_load_stall_r11: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !in_ready && !halted);

    p_redir_on_accept_r10: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (in_valid && in_ready));

    p_lit_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_lit && int'(depth) < DEPTH)
        |=> int'(depth) == int'($past(depth)) + 1);
endmodule

bind stk_exec_unit stk_exec_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_lit(in_lit), .redir_valid(redir_valid), .mem_rd(mem_rd),
    .depth(depth), .psw(psw), .halted(halted),
    .fault_stack(fault_stack), .fault_unimpl(fault_unimpl)
);

// File: tb/stk_exec_unit_tb.sv
module stk_exec_unit_tb;
    localparam int CLK_T = 10;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_lit = 1'b0;
    logic [5:0]    in_syl = '0;
    logic [31:0]   in_word = '0;
    logic          in_ready, redir_valid, mem_rd, mem_wr;
    logic [31:0]   redir_pc, mem_addr, mem_wdata, mem_rdata, tos, psw;
    logic [CW-1:0] depth;
    logic          halted, fault_stack, fault_unimpl;

    always #(CLK_T/2) clk = ~clk;

    stk_exec_unit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_lit(in_lit), .in_syl(in_syl), .in_word(in_word),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tos(tos), .depth(depth), .psw(psw), .halted(halted),
        .fault_stack(fault_stack), .fault_unimpl(fault_unimpl)
    );

    // memory model: word returned the cycle after the read strobe
    logic [31:0] rd_addr_q = '0;
    always @(posedge clk) if (mem_rd) rd_addr_q <= mem_addr;
    assign mem_rdata = rd_addr_q ^ 32'hA5A5_0000;

    int  n_chk = 0, n_err = 0;
    bit  finished = 0;

    typedef struct { int kind; logic [31:0] a; logic [31:0] d; } evt_t; // 0 redirect, 1 read, 2 write
    evt_t exp_q[$];

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic expect_evt(int kind, logic [31:0] a, logic [31:0] d);
        evt_t e;
        e.kind = kind; e.a = a; e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic take(int kind, logic [31:0] a, logic [31:0] d);
        evt_t e;
        string tag;
        tag = (kind == 0) ? "R10 redirect" : "R11 memory";
        n_chk++;
        if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL %s unexpected event actual=%h expected=none", tag, a);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.a !== a || e.d !== d) begin
                n_err++;
                $display("FAIL %s actual=%0d/%h/%h expected=%0d/%h/%h",
                         tag, kind, a, d, e.kind, e.a, e.d);
            end
        end
    endtask

    // scoreboard monitor, sampled mid-cycle
    always @(negedge clk) if (!rst && !finished) begin
        if (redir_valid) take(0, redir_pc, 32'h0);
        if (mem_rd)      take(1, mem_addr, 32'h0);
        if (mem_wr)      take(2, mem_addr, mem_wdata);
    end

    task automatic do_reset();
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic send(bit lit, logic [5:0] s, logic [31:0] w);
        bit r;
        in_valid = 1'b1; in_lit = lit; in_syl = s; in_word = w;
        forever begin
            @(negedge clk); r = in_ready;
            @(posedge clk); #1;
            if (r) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic syl(logic [5:0] s);      send(1'b0, s, 32'h0); endtask
    task automatic lit(logic [31:0] w);     send(1'b1, 6'h0, w);  endtask

    task automatic offer_blocked(logic [5:0] s);
        in_valid = 1'b1; in_lit = 1'b0; in_syl = s;
        repeat (3) @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(CLK_T * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 depth", 32'(depth), 0);
        chk("R1 psw", psw, 0);
        chk("R1 ready", 32'(in_ready), 1);
        chk("R1 halted", 32'(halted), 0);
        chk("R1 faults", {30'b0, fault_stack, fault_unimpl}, 0);

        // R2 immediate and literal pushes
        syl(6'b111111);
        chk("R2 imm zero-extend", tos, 32'h1F);
        lit(32'hDEAD_BEEF);
        chk("R2 literal", tos, 32'hDEAD_BEEF);
        chk("R2 depth", 32'(depth), 2);

        // R4 / R5 stack-relative copy and overwrite
        do_reset();
        lit(32'hA); lit(32'hB); lit(32'hC);
        syl(6'b011010);
        chk("R4 copy offset 2", tos, 32'hA);
        chk("R4 depth", 32'(depth), 4);
        lit(32'hD);
        syl(6'b010010);
        chk("R5 depth after overwrite", 32'(depth), 4);
        chk("R5 top after overwrite", tos, 32'hA);
        syl(6'b011010);
        chk("R5 overwritten entry", tos, 32'hD);

        // R6 logic
        do_reset();
        lit(32'hF0F0_1234); lit(32'h0FF0_FF00); syl(6'b001000);
        chk("R6 AND", tos, 32'h00F0_1200);
        chk("R6 AND depth", 32'(depth), 1);
        lit(32'h0000_00FF); syl(6'b001001);
        chk("R6 OR", tos, 32'h00F0_12FF);
        lit(32'hFFFF_0000); syl(6'b001011);
        chk("R6 XOR", tos, 32'hFF0F_12FF);
        syl(6'b001010);
        chk("R6 NOT", tos, 32'h00F0_ED00);
        chk("R6 NOT depth", 32'(depth), 1);

        // R7 add and swap, R10 jump
        do_reset();
        lit(32'h7FFF_FFFF); syl(6'b100001); syl(6'b001100);
        chk("R7 ADD wrap", tos, 32'h8000_0000);
        lit(32'h1234_5678); syl(6'b001101);
        chk("R7 SWAP top", tos, 32'h8000_0000);
        expect_evt(0, 32'h8000_0000, 32'h0);
        syl(6'b001110);
        chk("R7 SWAP next / R10 JMP pop", tos, 32'h1234_5678);
        chk("R10 JMP depth", 32'(depth), 1);
        chk("R9 psw untouched", psw, 0);

        // R8 signed shift
        do_reset();
        lit(32'hF0); syl(6'b100100); syl(6'b000100);
        chk("R8 shift left", tos, 32'hF00);
        lit(32'hFFFF_FFFC); syl(6'b000100);
        chk("R8 shift right", tos, 32'hF0);
        lit(32'd32); syl(6'b000100);
        chk("R8 shift 32", tos, 32'h0);
        chk("R8 depth", 32'(depth), 1);

        // R9 test, R12 nop
        do_reset();
        lit(32'h8000_0001); syl(6'b000110);
        chk("R9 negative", psw, 32'h2);
        chk("R9 depth", 32'(depth), 0);
        lit(32'h0); syl(6'b000110);
        chk("R9 zero", psw, 32'h1);
        syl(6'b100011); syl(6'b000110);
        chk("R9 positive", psw, 32'h0);
        lit(32'h8000_0000); syl(6'b000110); syl(6'b000001);
        chk("R12 NOP psw", psw, 32'h2);
        chk("R12 NOP depth", 32'(depth), 0);

        // R10 branch on zero
        do_reset();
        lit(32'h0); lit(32'h100);
        expect_evt(0, 32'h100, 32'h0);
        syl(6'b000111);
        chk("R10 BRZ taken depth", 32'(depth), 0);
        syl(6'b100111); lit(32'h200); syl(6'b000111);
        chk("R10 BRZ not taken depth", 32'(depth), 0);

        // R11 load and store
        do_reset();
        lit(32'h40);
        expect_evt(1, 32'h40, 32'h0);
        syl(6'b000010);
        chk("R11 load stall", 32'(in_ready), 0);
        @(posedge clk); #1;
        chk("R11 load data", tos, 32'hA5A5_0040);
        chk("R11 load depth", 32'(depth), 1);
        lit(32'h55); lit(32'h80);
        expect_evt(2, 32'h80, 32'h55);
        syl(6'b000011);
        chk("R11 store depth", 32'(depth), 1);
        chk("R11 store top", tos, 32'hA5A5_0040);

        // R3 underflow, overflow, copy beyond depth
        do_reset();
        syl(6'b001000);
        chk("R3 underflow fault", 32'(fault_stack), 1);
        chk("R3 underflow halted", 32'(halted), 1);
        chk("R3 underflow depth", 32'(depth), 0);
        do_reset();
        for (int i = 0; i < DEPTH; i++) syl(6'b100000 | 6'(i));
        chk("R3 full depth", 32'(depth), DEPTH);
        syl(6'b111111);
        chk("R3 overflow fault", 32'(fault_stack), 1);
        chk("R3 overflow depth", 32'(depth), DEPTH);
        chk("R3 overflow top kept", tos, 32'(DEPTH - 1));
        do_reset();
        lit(32'h1); syl(6'b011001);
        chk("R3 copy beyond depth", 32'(fault_stack), 1);
        chk("R3 copy beyond top kept", tos, 32'h1);

        // R12 halt
        do_reset();
        syl(6'b100001); syl(6'b000000);
        chk("R12 halted", 32'(halted), 1);
        chk("R12 not ready", 32'(in_ready), 0);
        offer_blocked(6'b100010);
        chk("R12 top kept", tos, 32'h1);
        chk("R12 depth kept", 32'(depth), 1);

        // R13 unimplemented opcodes
        do_reset();
        lit(32'h9); syl(6'b000101);
        chk("R13 cas flag", 32'(fault_unimpl), 1);
        chk("R13 cas halted", 32'(halted), 1);
        chk("R13 cas no stack fault", 32'(fault_stack), 0);
        chk("R13 cas depth", 32'(depth), 1);
        do_reset();
        syl(6'b001111);
        chk("R13 ctx flag", 32'(fault_unimpl), 1);

        chk("R10 R11 all events seen", 32'(exp_q.size()), 0);
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end
endmodule